// File: doc/BRIEF.md
# Frame-Axis Reorder Buffer for 8x8x8 Transform Cubes

This block sits between a per-frame two-dimensional transform and a one-dimensional transform that runs along the time axis of an N x N x N video cube (N = 8 by default). The upstream stage delivers one coefficient per clock. Within a frame the coefficients come row by row, and whole frames follow one another. The downstream stage needs the N coefficients that share a row/column position in the N frames of the cube, delivered back to back. Two members of such a vector enter the buffer N² accepted samples apart. The buffer therefore gathers a whole cube before it emits anything.

The store is not one square array. Each cube set is split into N banks, one bank per frame, and each bank holds the N² positions of that frame. A write is steered to the bank of the current frame, at the address of the current position. A read takes one bank per cycle and cycles through the frame index fastest. A registered selector returns the chosen bank's word to the output. Two cube sets alternate, so one cube can be written while the previous one is read out, and the output runs at one word per clock when the input does.

Top module: `tpose_frame_buf`

## Requirements
- R1: After reset `out_valid` and `out_vstart` are low, and they stay low until a complete cube of N³ accepted samples has been written.
- R2: For every complete cube written, exactly N³ output words are produced.
- R3: Take accepted sample k of a cube, with frame f = k / N² and position p = k mod N². That sample appears as output word j = p·N + f of the cube, so the output is position-major with the frame index running fastest.
- R4: `out_vstart` is high exactly on the output words that carry frame 0, which is every N-th word of a cube starting with its first. Every output burst opens with `out_vstart` high.
- R5: Once a cube starts to emit, its N³ words come on consecutive clock cycles.
- R6: Cycles with `in_valid` low do not advance the write position, and `in_data` has no effect on them.
- R7: At full input rate, the first word of a cube becomes visible N³+1 clock edges after the edge that accepts the cube's first sample. This is 513 for N = 8.
- R8: When cubes arrive back to back at full rate, the output stays valid with no idle cycle between the last word of one cube and the first word of the next.
- R9: When no further complete cube is pending, `out_valid` returns low after the last word of a cube.
- R10: A reset in the middle of a cube discards the partial cube. The next accepted sample is taken as frame 0, position 0 of a new cube.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | DW | Coefficient from the per-frame transform |
| out_valid | output | 1 | Output word present this cycle |
| out_vstart | output | 1 | Output word is frame 0 of a time-axis vector |
| out_data | output | DW | Reordered coefficient |

## Verification
The bench builds the block with N = 8 and DW = 16. Each input word is therefore tagged with its cube number times 512 plus its index in the cube, and the bench can check every output word against the permutation restated from R3. With N = 8, the distance of 64 samples between vector members, the 513-edge latency and the hand-over between the two cube sets all occur at their real sizes. The bench also covers irregular input gaps carrying junk data, three cubes in a row, and a reset that cuts a 511-sample cube short.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  // pointer width for a counter spanning n values (at least one bit)
  function automatic int ptr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // words held by one cube set
  function automatic int cube_words(input int n);
    return n * n * n;
  endfunction

  // edges from acceptance of a cube's first sample to its first output word
  function automatic int cube_latency(input int n);
    return n * n * n + 1;
  endfunction

endpackage

// File: rtl/tpose_bank.sv
module tpose_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/tpose_wr_ctrl.sv
module tpose_wr_ctrl #(
  parameter int N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  output logic [tpose_pkg::ptr_w(N*N)-1:0]     wr_pos,
  output logic [tpose_pkg::ptr_w(N)-1:0]       wr_frame,
  output logic                                 wr_set,
  output logic                                 cube_done
);
  import tpose_pkg::*;

  localparam int PW = ptr_w(N * N);
  localparam int FW = ptr_w(N);
  localparam logic [PW-1:0] PLAST = PW'(N * N - 1);
  localparam logic [FW-1:0] FLAST = FW'(N - 1);

  logic [PW-1:0] pos_q;
  logic [FW-1:0] frame_q;
  logic          set_q;
  logic          plane_end;

  assign plane_end = (pos_q == PLAST);
  assign cube_done = in_valid && plane_end && (frame_q == FLAST);
  assign wr_pos    = pos_q;
  assign wr_frame  = frame_q;
  assign wr_set    = set_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      frame_q <= '0;
      set_q   <= 1'b0;
    end else if (in_valid) begin
      if (!plane_end) begin
        pos_q <= pos_q + 1'b1;
      end else begin
        pos_q <= '0;
        if (frame_q == FLAST) begin
          frame_q <= '0;
          set_q   <= ~set_q;
        end else begin
          frame_q <= frame_q + 1'b1;
        end
      end
    end
  end

  // R6: idle input cycles leave the write pointer untouched
  a_r6_hold_pointer: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pos_q) && $stable(frame_q) && $stable(set_q));

endmodule

// File: rtl/tpose_rd_ctrl.sv
module tpose_rd_ctrl #(
  parameter int N = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 cube_done,
  input  logic                                 done_set,
  output logic                                 rd_fire,
  output logic                                 rd_set,
  output logic [tpose_pkg::ptr_w(N*N)-1:0]     rd_pos,
  output logic [tpose_pkg::ptr_w(N)-1:0]       rd_frame,
  output logic                                 rd_first
);
  import tpose_pkg::*;

  localparam int PW = ptr_w(N * N);
  localparam int FW = ptr_w(N);
  localparam logic [PW-1:0] PLAST = PW'(N * N - 1);
  localparam logic [FW-1:0] FLAST = FW'(N - 1);

  logic [1:0]    full_q, full_d;
  logic          busy_q;
  logic          set_q;
  logic [PW-1:0] pos_q;
  logic [FW-1:0] frame_q;
  logic          rd_last;
  logic          take;
  logic          take_set;

  assign rd_last  = busy_q && (pos_q == PLAST) && (frame_q == FLAST);
  assign take_set = busy_q ? ~set_q : set_q;
  assign take     = busy_q ? (rd_last && full_q[take_set]) : full_q[take_set];

  always_comb begin
    full_d = full_q;
    if (take)      full_d[take_set] = 1'b0;
    if (cube_done) full_d[done_set] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= '0;
      busy_q  <= 1'b0;
      set_q   <= 1'b0;
      pos_q   <= '0;
      frame_q <= '0;
    end else begin
      full_q <= full_d;
      if (!busy_q) begin
        if (take) begin
          busy_q  <= 1'b1;
          pos_q   <= '0;
          frame_q <= '0;
        end
      end else if (frame_q != FLAST) begin
        frame_q <= frame_q + 1'b1;
      end else begin
        frame_q <= '0;
        if (pos_q != PLAST) begin
          pos_q <= pos_q + 1'b1;
        end else begin
          pos_q  <= '0;
          set_q  <= ~set_q;
          busy_q <= take;
        end
      end
    end
  end

  assign rd_fire  = busy_q;
  assign rd_set   = set_q;
  assign rd_pos   = pos_q;
  assign rd_frame = frame_q;
  assign rd_first = (frame_q == '0);

  // R5: a cube in progress is read on every cycle until its last word
  a_r5_no_gap: assert property (@(posedge clk) disable iff (rst)
    busy_q && !rd_last |=> busy_q);

  // R8: a waiting cube is picked up directly after the last word of the current one
  a_r8_chain: assert property (@(posedge clk) disable iff (rst)
    rd_last && full_q[~set_q] |=> busy_q && (pos_q == '0) && (frame_q == '0));

  // R2: a finished cube never lands on a set that is still waiting to be read
  a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
    cube_done |-> !full_q[done_set]);

endmodule

// File: rtl/tpose_frame_buf.sv
module tpose_frame_buf #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_vstart,
  output logic [DW-1:0] out_data
);
  import tpose_pkg::*;

  localparam int PW    = ptr_w(N * N);
  localparam int FW    = ptr_w(N);
  localparam int PLANE = N * N;

  logic [PW-1:0] wr_pos;
  logic [FW-1:0] wr_frame;
  logic          wr_set;
  logic          cube_done;

  logic          rd_fire;
  logic          rd_set;
  logic [PW-1:0] rd_pos;
  logic [FW-1:0] rd_frame;
  logic          rd_first;

  logic [DW-1:0] bank_q [2][N];

  logic          valid_q;
  logic          vstart_q;
  logic          sel_set_q;
  logic [FW-1:0] sel_frame_q;

  tpose_wr_ctrl #(.N(N)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .wr_pos    (wr_pos),
    .wr_frame  (wr_frame),
    .wr_set    (wr_set),
    .cube_done (cube_done)
  );

  tpose_rd_ctrl #(.N(N)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .cube_done (cube_done),
    .done_set  (wr_set),
    .rd_fire   (rd_fire),
    .rd_set    (rd_set),
    .rd_pos    (rd_pos),
    .rd_frame  (rd_frame),
    .rd_first  (rd_first)
  );

  // write demux and read select: one bank per (cube set, frame)
  for (genvar s = 0; s < 2; s++) begin : g_set
    for (genvar f = 0; f < N; f++) begin : g_frame
      logic we_l;
      logic re_l;
      assign we_l = in_valid && (wr_set == 1'(s)) && (wr_frame == FW'(f));
      assign re_l = rd_fire && (rd_set == 1'(s)) && (rd_frame == FW'(f));
      tpose_bank #(.DW(DW), .DEPTH(PLANE), .AW(PW)) u_bank (
        .clk   (clk),
        .we    (we_l),
        .waddr (wr_pos),
        .wdata (in_data),
        .re    (re_l),
        .raddr (rd_pos),
        .rdata (bank_q[s][f])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= 1'b0;
      vstart_q    <= 1'b0;
      sel_set_q   <= 1'b0;
      sel_frame_q <= '0;
    end else begin
      valid_q  <= rd_fire;
      vstart_q <= rd_fire && rd_first;
      if (rd_fire) begin
        sel_set_q   <= rd_set;
        sel_frame_q <= rd_frame;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_vstart = vstart_q;
  assign out_data   = bank_q[sel_set_q][sel_frame_q];

  // R4: the vector marker only rides on a valid word
  a_r4_vstart_in_burst: assert property (@(posedge clk) disable iff (rst)
    out_vstart |-> out_valid);

  // R4: every burst opens on frame 0 of a vector
  a_r4_burst_opens_vector: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_vstart);

endmodule

// File: tb/sim_tpose_frame_buf.sv
module sim_tpose_frame_buf;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_vstart;
  logic [15:0] out_data;

  int nchk = 0;
  int nbad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [15:0] q_d[$];
  bit          q_v[$];
  int          q_t[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      q_d.push_back(out_data);
      q_v.push_back(out_vstart);
      q_t.push_back(cyc);
    end
  end

  tpose_frame_buf #(.N(8), .DW(16)) u0 (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_vstart (out_vstart),
    .out_data   (out_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_q();
    q_d.delete();
    q_v.delete();
    q_t.delete();
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic idle_in();
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data  = 16'h0;
  endtask

  // drive 'count' samples tagged tag*512+i; gaps carry junk data
  task automatic send_cube(input int tag, input int count, input bit gaps,
                           output int first_acc);
    first_acc = -1;
    for (int i = 0; i < count; i++) begin
      if (gaps && (i % 7 == 3)) begin
        for (int g = 0; g <= (i % 3); g++) begin
          @(posedge clk); #1;
          in_valid = 1'b0;
          in_data  = 16'hBEEF ^ 16'(i);
        end
      end
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_data  = 16'(tag * 512 + i);
      if (first_acc < 0) first_acc = cyc + 1;
    end
  endtask

  task automatic wait_words(input int target);
    int w = 0;
    while (q_d.size() < target && w < 6000) begin
      @(posedge clk);
      w++;
    end
    repeat (30) @(posedge clk);
  endtask

  // compare the collected stream against the restated permutation
  task automatic check_stream(input int ncubes, input int tag0, input string req_ord);
    int bad_ord = 0, bad_vs = 0, bad_gap = 0;
    int fa = 0, fe = 0, va = 0, ve = 0, ga = 0, ge = 0;
    chk(q_d.size() == ncubes * 512, "R2", "word count", q_d.size(), ncubes * 512);
    for (int j = 0; j < q_d.size() && j < ncubes * 512; j++) begin
      int c  = j / 512;
      int jj = j % 512;
      int exp_src = (jj % 8) * 64 + (jj / 8);
      int exp_val = (tag0 + c) * 512 + exp_src;
      bit exp_vs  = (jj % 8 == 0);
      if (int'(q_d[j]) != exp_val) begin
        if (bad_ord == 0) begin fa = int'(q_d[j]); fe = exp_val; end
        bad_ord++;
      end
      if (q_v[j] != exp_vs) begin
        if (bad_vs == 0) begin va = int'(q_v[j]); ve = int'(exp_vs); end
        bad_vs++;
      end
      if (q_t[j] != q_t[0] + j) begin
        if (bad_gap == 0) begin ga = q_t[j]; ge = q_t[0] + j; end
        bad_gap++;
      end
    end
    chk(bad_ord == 0, req_ord, "order first mismatch", fa, fe);
    chk(bad_vs == 0, "R4", "vstart first mismatch", va, ve);
    chk(bad_gap == 0, (ncubes > 1) ? "R8" : "R5", "stamp of word", ga, ge);
    chk(out_valid == 1'b0, "R9", "out_valid after stream", int'(out_valid), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(out_vstart == 1'b0, "R1", "out_vstart after reset", int'(out_vstart), 0);
  endtask

  task automatic t_partial_then_reset();
    int fa;
    clear_q();
    send_cube(5, 511, 1'b0, fa);
    idle_in();
    repeat (600) @(posedge clk);
    chk(q_d.size() == 0, "R1", "words from partial cube", q_d.size(), 0);
    do_reset();
  endtask

  task automatic t_single();
    int fa;
    clear_q();
    send_cube(2, 512, 1'b0, fa);
    idle_in();
    wait_words(512);
    check_stream(1, 2, "R3");
    if (q_d.size() > 0) begin
      chk(int'(q_d[0]) == 2 * 512, "R10", "first word after mid-cube reset",
          int'(q_d[0]), 2 * 512);
      chk(q_t[0] - fa == 513, "R7", "latency", q_t[0] - fa, 513);
    end else begin
      chk(1'b0, "R7", "no output", 0, 513);
    end
  endtask

  task automatic t_gaps();
    int fa;
    clear_q();
    send_cube(3, 512, 1'b1, fa);
    idle_in();
    wait_words(512);
    check_stream(1, 3, "R6");
  endtask

  task automatic t_back_to_back();
    int fa, fb;
    clear_q();
    send_cube(10, 512, 1'b0, fa);
    send_cube(11, 512, 1'b0, fb);
    send_cube(12, 512, 1'b0, fb);
    idle_in();
    wait_words(3 * 512);
    check_stream(3, 10, "R3");
    if (q_d.size() > 0)
      chk(q_t[0] - fa == 513, "R7", "latency back to back", q_t[0] - fa, 513);
  endtask

  initial begin
    t_reset_state();
    t_partial_then_reset();
    t_single();
    t_gaps();
    t_back_to_back();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog run incomplete act=%0d exp=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule